// File: doc/BRIEF.md
# Processor Hotplug Presence and Event Registers

This block keeps a presence bitmap for up to 256 processors and a small general-purpose event register set. A management agent sends hot-add and hot-remove commands, each carrying a processor index and a direction flag. Each command updates that processor's presence bit. Each command also sets one shared event-status bit. Firmware can then read the bitmap to find out which processors changed state.

The bitmap and the event registers are exposed on a byte-wide I/O port. The event block holds two status bytes, which are cleared by writing 1 to a bit, and two enable bytes, which are plain read/write. The level-sensitive interrupt output stays high while any status bit and its matching enable bit are both set. A separate input sets the status bit reserved for slot hotplug. At reset, the bitmap is seeded from the boot processor count presented on `boot_cpus`.

Top module: `cpuhp_regs`

## Requirements
- R1: While `rst` is high, the bitmap loads N = `boot_cpus` ones into its lowest N bits. Processor n is bit (n mod 8) of the byte read at 0xAF00 + (n div 8). Each full group of eight reads as 0xFF, a final group of r processors reads as (1<<r)-1, and all other bytes read as 0x00.
- R2: A command with `hp_valid`=1 and `hp_add`=1 sets the bit for processor `hp_cpu` at the next clock edge. All other bitmap bits keep their values.
- R3: A command with `hp_valid`=1 and `hp_add`=0 clears the bit for processor `hp_cpu` at the next clock edge.
- R4: Every command sets bit 2 (value 0x04) of status byte 0, which is at 0xAFE0. The bit stays set after the command ends. A command that does not change the bitmap (adding a present processor or removing an absent one) still sets this bit.
- R5: A one-cycle pulse on `pci_evt` sets bit 1 (value 0x02) of status byte 0.
- R6: The event block spans 0xAFE0 to 0xAFE3. Status bytes 0 and 1 are at offsets 0 and 1. Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged. Enable bytes 0 and 1 are at offsets 2 and 3 and read back the value last written. All four bytes read as zero after reset.
- R7: `sci` is high exactly when some status bit and the same bit of the matching enable byte are both 1. It follows register changes in the cycle after the edge that makes them.
- R8: Writes to 0xAF00 to 0xAF1F change nothing. Reads from any address outside the bitmap and the event block return 0x00.
- R9: If a status-clearing write and an event set hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the bitmap seed |
| boot_cpus | input | 9 | Boot processor count, sampled while `rst` is high |
| hp_valid | input | 1 | Hotplug command strobe, one cycle per command |
| hp_cpu | input | 8 | Processor index of the command |
| hp_add | input | 1 | 1 = add, 0 = remove |
| pci_evt | input | 1 | Pulse that sets the slot hotplug status bit |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| sci | output | 1 | Level interrupt: any enabled status bit set |

## Verification
A bad bitmap bit shows up as a wrong byte in the first read of that processor's byte after the command edge. A wrong seed shows up in the first read after reset. A status bit that is lost or stuck shows up on the next read of 0xAFE0. If its enable bit is set, it also shows on `sci` in the following cycle, which is tested with enables both on and off. The same-cycle clear-and-set case and redundant commands are driven on purpose, because an error in either leaves the bitmap looking correct while the event status is wrong.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned GPE_HALF    = 2;
    localparam int unsigned GPE_LEN     = 2 * GPE_HALF;
    localparam int unsigned EVT_PCI_BIT = 1;
    localparam int unsigned EVT_CPU_BIT = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [GPE_HALF-1:0][BYTE_W-1:0] sts;
        logic [GPE_HALF-1:0][BYTE_W-1:0] en;
    } gpe_state_t;

endpackage

// File: rtl/cpuhp_presence.sv
module cpuhp_presence #(
    parameter int unsigned MAX_CPUS = 256,
    localparam int unsigned IDX_W   = $clog2(MAX_CPUS),
    localparam int unsigned CNT_W   = $clog2(MAX_CPUS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    boot_cpus,
    input  logic                hp_valid,
    input  logic [IDX_W-1:0]    hp_cpu,
    input  logic                hp_add,
    output logic [MAX_CPUS-1:0] map_o
);

    typedef struct packed {
        logic [MAX_CPUS-1:0] map;
    } pres_t;

    pres_t               st_d, st_q;
    logic [MAX_CPUS-1:0] seed;

    // Seed: the lowest boot_cpus bits are ones
    for (genvar i = 0; i < MAX_CPUS; i++) begin : g_seed
        assign seed[i] = (CNT_W'(i) < boot_cpus);
    end

    always_comb begin
        st_d = st_q;
        if (hp_valid) begin
            st_d.map[hp_cpu] = hp_add;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.map <= seed;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_o = st_q.map;

    assert_add_sets_R2: assert property (@(posedge clk) disable iff (rst)
        hp_valid && hp_add |=> map_o[$past(hp_cpu)]);

    assert_remove_clears_R3: assert property (@(posedge clk) disable iff (rst)
        hp_valid && !hp_add |=> !map_o[$past(hp_cpu)]);

endmodule

// File: rtl/cpuhp_gpe.sv
module cpuhp_gpe
    import cpuhp_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [1:0]                       wr_off,
    input  logic [BYTE_W-1:0]                wr_data,
    input  logic                             cpu_evt,
    input  logic                             pci_evt,
    output logic [GPE_HALF-1:0][BYTE_W-1:0]  sts_o,
    output logic [GPE_HALF-1:0][BYTE_W-1:0]  en_o,
    output logic                             sci_o
);

    gpe_state_t gpe_d, gpe_q;

    always_comb begin
        gpe_d = gpe_q;
        if (wr_en) begin
            case (wr_off)
                2'd0:    gpe_d.sts[0] = gpe_q.sts[0] & ~wr_data;
                2'd1:    gpe_d.sts[1] = gpe_q.sts[1] & ~wr_data;
                2'd2:    gpe_d.en[0]  = wr_data;
                default: gpe_d.en[1]  = wr_data;
            endcase
        end
        // event sets are applied after the clear, so a set wins
        if (cpu_evt) gpe_d.sts[0][EVT_CPU_BIT] = 1'b1;
        if (pci_evt) gpe_d.sts[0][EVT_PCI_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gpe_q <= '0;
        end else begin
            gpe_q <= gpe_d;
        end
    end

    assign sts_o = gpe_q.sts;
    assign en_o  = gpe_q.en;
    assign sci_o = |(gpe_q.sts & gpe_q.en);

    assert_cpu_evt_sets_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_evt |=> sts_o[0][EVT_CPU_BIT]);

    assert_pci_evt_sets_R5: assert property (@(posedge clk) disable iff (rst)
        pci_evt |=> sts_o[0][EVT_PCI_BIT]);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_off == 2'd0 && wr_data == 8'hFF && !cpu_evt && !pci_evt
        |=> sts_o[0] == '0);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        pci_evt && wr_en && wr_off == 2'd0 && wr_data[EVT_PCI_BIT]
        |=> sts_o[0][EVT_PCI_BIT]);

endmodule

// File: rtl/cpuhp_regs.sv
module cpuhp_regs
    import cpuhp_pkg::*;
#(
    parameter int unsigned          MAX_CPUS  = 256,
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    MAP_BASE  = 16'hAF00,
    parameter logic [ADDR_W-1:0]    GPE_BASE  = 16'hAFE0,
    localparam int unsigned         IDX_W     = $clog2(MAX_CPUS),
    localparam int unsigned         CNT_W     = $clog2(MAX_CPUS + 1),
    localparam int unsigned         MAP_BYTES = MAX_CPUS / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  boot_cpus,
    input  logic              hp_valid,
    input  logic [IDX_W-1:0]  hp_cpu,
    input  logic              hp_add,
    input  logic              pci_evt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              sci
);

    logic [MAX_CPUS-1:0]             map_w;
    logic [GPE_HALF-1:0][BYTE_W-1:0] sts_w, en_w;
    logic                            map_hit, gpe_hit;
    logic [1:0]                      gpe_off;

    cpuhp_presence #(.MAX_CPUS(MAX_CPUS)) u_presence (
        .clk       (clk),
        .rst       (rst),
        .boot_cpus (boot_cpus),
        .hp_valid  (hp_valid),
        .hp_cpu    (hp_cpu),
        .hp_add    (hp_add),
        .map_o     (map_w)
    );

    cpuhp_gpe u_gpe (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (io_wr && gpe_hit),
        .wr_off  (gpe_off),
        .wr_data (io_wdata),
        .cpu_evt (hp_valid),
        .pci_evt (pci_evt),
        .sts_o   (sts_w),
        .en_o    (en_w),
        .sci_o   (sci)
    );

    // Address decode and read mux
    always_comb begin
        io_rdata = '0;
        map_hit  = 1'b0;
        gpe_hit  = 1'b0;
        gpe_off  = 2'd0;
        for (int k = 0; k < MAP_BYTES; k++) begin
            if (io_addr == MAP_BASE + ADDR_W'(k)) begin
                map_hit  = 1'b1;
                io_rdata = map_w[k*BYTE_W +: BYTE_W];
            end
        end
        for (int k = 0; k < GPE_LEN; k++) begin
            if (io_addr == GPE_BASE + ADDR_W'(k)) begin
                gpe_hit = 1'b1;
                gpe_off = 2'(k);
                io_rdata = (k < GPE_HALF) ? sts_w[k % GPE_HALF] : en_w[k % GPE_HALF];
            end
        end
    end

    assert_map_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        io_wr && map_hit && !hp_valid |=> $stable(map_w));

    assert_sci_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sci) |-> $past(hp_valid || pci_evt || (io_wr && gpe_hit)));

endmodule

// File: tb/cpuhp_regs_test.sv
`timescale 1ns/1ps
module cpuhp_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  boot_cpus = 9'd11;
    logic        hp_valid = 1'b0;
    logic [7:0]  hp_cpu = '0;
    logic        hp_add = 1'b0;
    logic        pci_evt = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sci;

    always #4 clk = ~clk;   // 125 MHz

    cpuhp_regs uut (
        .clk(clk), .rst(rst), .boot_cpus(boot_cpus), .hp_valid(hp_valid),
        .hp_cpu(hp_cpu), .hp_add(hp_add), .pci_evt(pci_evt), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .sci(sci)
    );

    localparam logic [15:0] MAP = 16'hAF00;
    localparam logic [15:0] GPE = 16'hAFE0;

    // reference model
    bit [255:0] m_map;
    bit [7:0]   m_sts [2];
    bit [7:0]   m_en  [2];

    // scoreboard: bit 8 selects an sci check
    int    exp_q[$];
    string tag_q[$];
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;

    function automatic bit [7:0] model_rd(input logic [15:0] a);
        if (a >= MAP && a < MAP + 16'd32) return m_map[(a - MAP)*8 +: 8];
        if (a == GPE)         return m_sts[0];
        if (a == GPE + 16'd1) return m_sts[1];
        if (a == GPE + 16'd2) return m_en[0];
        if (a == GPE + 16'd3) return m_en[1];
        return 8'h00;
    endfunction

    function automatic bit model_sci();
        return |((m_sts[0] & m_en[0]) | (m_sts[1] & m_en[1]));
    endfunction

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (e[8]) begin
                    if (sci !== e[0]) begin
                        n_fail++;
                        $display("FAIL %s: sci actual %b expected %b", t, sci, e[0]);
                    end
                end else if (io_rdata !== e[7:0]) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %02h expected %02h", t, io_rdata, e[7:0]);
                end
            end
        end
    end

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1; boot_cpus = 9'(n);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) m_map[i] = (i < n);
        m_sts = '{8'h0, 8'h0}; m_en = '{8'h0, 8'h0};
    endtask

    task automatic rd(input logic [15:0] a, input string t);
        @(negedge clk);
        io_addr = a;
        exp_q.push_back(int'(model_rd(a)));
        tag_q.push_back(t);
        @(posedge clk);
    endtask

    task automatic chk_sci(input string t);
        @(negedge clk);
        exp_q.push_back(256 | int'(model_sci()));
        tag_q.push_back(t);
        @(posedge clk);
    endtask

    task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
        if (a == GPE)         m_sts[0] &= ~d;
        if (a == GPE + 16'd1) m_sts[1] &= ~d;
        if (a == GPE + 16'd2) m_en[0] = d;
        if (a == GPE + 16'd3) m_en[1] = d;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic hp(input int cpu, input bit add);
        @(negedge clk);
        hp_valid = 1'b1; hp_cpu = 8'(cpu); hp_add = add;
        @(posedge clk); #1;
        hp_valid = 1'b0;
        m_map[cpu] = add;
        m_sts[0] |= 8'h04;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: seed with 11 boot processors -> FF 07 00 ...
        do_reset(11);
        rd(MAP,          "R1 byte0 full group");
        rd(MAP + 16'd1,  "R1 byte1 partial group");
        rd(MAP + 16'd2,  "R1 byte2 zero");
        rd(MAP + 16'd31, "R1 last byte zero");
        // R6: event block resets to zero
        for (int k = 0; k < 4; k++) rd(GPE + 16'(k), "R6 reset value");
        chk_sci("R7 low after reset");

        // R2 / R4: add processor 200 -> byte 25 bit 0; status 0x04, not enabled
        hp(200, 1'b1);
        rd(MAP + 16'd25, "R2 add sets bit");
        rd(GPE,          "R4 status bit set by add");
        chk_sci("R7 low with enable clear");

        // R6 / R7: enable then clear
        wr(GPE + 16'd2, 8'h04);
        rd(GPE + 16'd2, "R6 enable readback");
        chk_sci("R7 high when enabled");
        wr(GPE, 8'h04);
        rd(GPE, "R6 write one clears");
        chk_sci("R7 low after clear");

        // R3: remove processor 3 -> byte0 0xF7
        hp(3, 1'b0);
        rd(MAP, "R3 remove clears bit");
        rd(GPE, "R4 status bit set by remove");
        chk_sci("R7 high after remove");

        // R4: redundant commands
        wr(GPE, 8'hFF);
        hp(3, 1'b0);
        rd(MAP, "R4 redundant remove keeps map");
        rd(GPE, "R4 redundant remove sets status");
        hp(0, 1'b1);
        rd(MAP, "R4 redundant add keeps map");

        // R5: slot hotplug status bit
        @(negedge clk); pci_evt = 1'b1;
        @(posedge clk); #1; pci_evt = 1'b0; m_sts[0] |= 8'h02;
        rd(GPE, "R5 slot event bit");
        wr(GPE, 8'h04);
        rd(GPE, "R6 partial clear keeps other bit");

        // R9: clear-all and event set in the same cycle
        @(negedge clk);
        io_addr = GPE; io_wdata = 8'hFF; io_wr = 1'b1;
        hp_valid = 1'b1; hp_cpu = 8'd100; hp_add = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0; hp_valid = 1'b0;
        m_sts[0] = 8'h04; m_map[100] = 1'b1;
        rd(GPE,          "R9 set wins over clear");
        rd(MAP + 16'd12, "R2 add processor 100");

        // R8: bitmap writes ignored, unmapped reads zero
        wr(MAP, 8'h00);
        rd(MAP, "R8 bitmap write ignored");
        wr(MAP + 16'd25, 8'h00);
        rd(MAP + 16'd25, "R8 bitmap write ignored high byte");
        rd(MAP + 16'd32, "R8 unmapped above bitmap");
        rd(GPE + 16'd4,  "R8 unmapped above event block");
        rd(16'h1234,     "R8 unmapped far");

        // R6: second enable byte and second status byte
        wr(GPE + 16'd3, 8'hA5);
        rd(GPE + 16'd3, "R6 enable1 readback");
        wr(GPE + 16'd1, 8'hFF);
        rd(GPE + 16'd1, "R6 status1 stays zero");

        // R1: other seeds
        do_reset(16);
        rd(MAP,         "R1 seed16 byte0");
        rd(MAP + 16'd1, "R1 seed16 byte1");
        rd(MAP + 16'd2, "R1 seed16 byte2");
        do_reset(256);
        rd(MAP,          "R1 seed256 byte0");
        rd(MAP + 16'd31, "R1 seed256 byte31");
        do_reset(0);
        rd(MAP, "R1 seed0 byte0");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule